// File: doc/BRIEF.md
# Sequential One's Complement Multiplier

This block multiplies two N-bit one's complement operands over several clock cycles and returns a 2N-bit one's complement product. One operand is the multiplicand; the other is the multiplier, whose bits are examined one per cycle starting at the least significant end. For each multiplier bit that is set, the multiplicand, weighted by that bit's position, is added into a double-length accumulator. Every addition uses end-around carry.

A negative multiplier needs two corrections, because its sign bit has weight -(2^(N-1) - 1).

- The accumulator starts at the multiplicand instead of zero. This supplies the +A part of the sign weight.
- After the ordinary steps, one correction step subtracts 2^(N-1)·A. It does this by adding the bitwise inverse of the sign-extended, double-length multiplicand.

A negative multiplicand needs no special treatment. Its one's complement multiples are simply added.

To use the block, raise `start` for one cycle with both operands valid. Then wait for the single-cycle `done` pulse. The product stays on `product_o` until the next accepted start.

Top module: `oc_seq_mult`

## Requirements
- R1: While reset (rst_n low, sampled on the rising clock edge) is applied, and afterwards until the first start, `done_o` is 0 and `product_o` is all zeros.
- R2: For a multiplier with bit N-1 equal to 0, the product value equals the arithmetic product of the operand values. The multiplicand may be of either sign.
- R3: For a multiplier with bit N-1 equal to 1, the product value equals the arithmetic product. This relies on the preset accumulator and the final double-length correction.
- R4: Either zero encoding (all zeros or all ones) is accepted on either operand. The resulting product has value zero, in either zero encoding.
- R5: `done_o` rises in the cycle after the (N+1)-th rising edge, counting the edge that samples `start`, and stays high for exactly one cycle.
- R6: A `start` that arrives while a multiplication is in progress, or during its `done` cycle, is ignored. The running result is unchanged.
- R7: After `done_o`, `product_o` holds its value until the next accepted `start`.
- R8: Every one's complement addition uses end-around carry, and no intermediate sum overflows. For example, (-1)·(-1) gives +1, and (-(2^(N-1)-1))^2 is exact.
- R9: Operands are N bits wide, with bit N-1 as the sign. The product is 2N bits wide, with bit 2N-1 as the sign. A negative value is the bitwise inverse of its magnitude; for example, -15 at N=6 is 12'hFF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request; sampled only when idle |
| mcand_i | input | N | Multiplicand, one's complement |
| mplier_i | input | N | Multiplier, one's complement |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| product_o | output | 2N | Product, one's complement |

## Verification
The hardest case to reach is a final correction whose end-around carry is taken. This only happens when the multiplier is negative and the accumulated sum wraps past the top bit.

An exhaustive sweep over all operand pairs at N=6 reaches every such case. The sweep includes both zero encodings on both inputs, so the correction path also sees -0 operands.

A directed run raises `start` in the middle of a multiplication with different operands, to show that the strobe is ignored. A second directed run idles after `done`, to show that the held product is stable.

// File: rtl/oc_mult_pkg.sv
// Package: shared types for the one's complement sequential multiplier.
// Assumes nothing beyond IEEE 1800-2017.
package oc_mult_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_CORR = 2'd2,
        PH_DONE = 2'd3
    } phase_t;
endpackage

// File: rtl/oc_eac_adder.sv
// oc_eac_adder: W-bit one's complement adder.
// A carry out of the top bit is added back in at the bottom (end-around carry).
// Assumes the caller keeps sums inside the representable range.
module oc_eac_adder #(
    parameter int W = 12
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    logic [W:0] raw;

    // Binary add, then fold the carry back into the least significant bit.
    always_comb begin
        raw   = {1'b0, a_i} + {1'b0, b_i};
        sum_o = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    end
endmodule

// File: rtl/oc_sign_ext.sv
// oc_sign_ext: widens a one's complement value by replicating its sign bit.
// This is exact in one's complement for both signs. Assumes WO >= WI.
module oc_sign_ext #(
    parameter int WI = 6,
    parameter int WO = 12
) (
    input  logic [WI-1:0] val_i,
    output logic [WO-1:0] val_o
);
    localparam int PAD = WO - WI;

    generate
        if (PAD == 0) begin : g_same
            // Equal widths: pass straight through.
            assign val_o = val_i;
        end else begin : g_pad
            // Fill the upper bits with copies of the sign.
            assign val_o = {{PAD{val_i[WI-1]}}, val_i};
        end
    endgenerate
endmodule

// File: rtl/oc_mult_ctrl.sv
// oc_mult_ctrl: sequencing for the multiplier.
// One load cycle, N-1 scan steps, one correction cycle, then a one-cycle done.
// Assumes N >= 3. Start is honoured only when idle.
module oc_mult_ctrl
    import oc_mult_pkg::*;
#(
    parameter int N = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load_o,
    output logic step_o,
    output logic corr_o,
    output logic done_o
);
    localparam int CW = (N > 2) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 2);

    phase_t        phase_q;
    logic [CW-1:0] cnt_q;

    // Decode the phase into strobes for the datapath.
    always_comb begin
        load_o = (phase_q == PH_IDLE) && start;
        step_o = (phase_q == PH_RUN);
        corr_o = (phase_q == PH_CORR);
        done_o = (phase_q == PH_DONE);
    end

    // Phase register and scan-step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (start) begin
                    phase_q <= PH_RUN;
                    cnt_q   <= '0;
                end
                PH_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) phase_q <= PH_CORR;
                end
                PH_CORR: phase_q <= PH_DONE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RUN) |-> (cnt_q <= LAST)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5
    AST_DONE_AFTER_CORR: assert property (@(posedge clk) disable iff (!rst_n)
        corr_o |=> done_o); // R5
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && cnt_q != LAST) |=> step_o); // R6
endmodule

// File: rtl/oc_seq_mult.sv
// oc_seq_mult: sequential one's complement multiplier, N-bit operands, 2N-bit product.
// Scans multiplier bits from the low end while the multiplicand shifts left.
// A negative multiplier presets the accumulator to A; a final step then adds
// the inverse of A*2^(N-1). Assumes N >= 3 and operands held only at start.
module oc_seq_mult #(
    parameter int N = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N-1:0]   mcand_i,
    input  logic [N-1:0]   mplier_i,
    output logic           done_o,
    output logic [2*N-1:0] product_o
);
    localparam int PW = 2 * N;

    logic          load, step, corr;
    logic [PW-1:0] a_ext, acc_q, mcand_q, addend, sum;
    logic [N-1:0]  mplier_q;
    logic          neg_q, add_en;

    oc_mult_ctrl #(.N(N)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load_o(load), .step_o(step), .corr_o(corr), .done_o(done_o)
    );

    oc_sign_ext #(.WI(N), .WO(PW)) u_ext (.val_i(mcand_i), .val_o(a_ext));

    // Choose the addend: the shifted multiplicand, or its inverse on correction.
    always_comb begin
        addend = corr ? ~mcand_q : mcand_q;
        add_en = (step && mplier_q[0]) || (corr && neg_q);
    end

    oc_eac_adder #(.W(PW)) u_add (.a_i(acc_q), .b_i(addend), .sum_o(sum));

    // Accumulator, shifting multiplicand and multiplier registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
            neg_q    <= 1'b0;
        end else if (load) begin
            acc_q    <= mplier_i[N-1] ? a_ext : '0;
            mcand_q  <= a_ext;
            mplier_q <= mplier_i;
            neg_q    <= mplier_i[N-1];
        end else if (step) begin
            if (mplier_q[0]) acc_q <= sum;
            mcand_q  <= {mcand_q[PW-2:0], mcand_q[PW-1]};
            mplier_q <= mplier_q >> 1;
        end else if (corr && neg_q) begin
            acc_q <= sum;
        end
    end

    assign product_o = acc_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && (addend[PW-1] == acc_q[PW-1])) |-> (sum[PW-1] == acc_q[PW-1])); // R8
    AST_PRODUCT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step && !corr) |=> $stable(product_o)); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (product_o == '0 && !done_o)); // R1
endmodule

// File: tb/test_oc_seq_mult.sv
// test_oc_seq_mult: exhaustive sweep plus directed cases for oc_seq_mult.
module test_oc_seq_mult;
    localparam int N  = 6;
    localparam int PW = 2 * N;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N-1:0]   mcand = '0;
    logic [N-1:0]   mplier = '0;
    logic           done;
    logic [PW-1:0]  product;

    int checks = 0;
    int fails  = 0;

    oc_seq_mult #(.N(N)) i_oc_seq_mult (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mcand_i(mcand), .mplier_i(mplier),
        .done_o(done), .product_o(product)
    );

    always #2 clk = ~clk;   // 250 MHz

    // Decode a w-bit one's complement pattern (R9).
    function automatic longint oc_val(input logic [63:0] v, input int w);
        logic [63:0] mask;
        mask = (64'd1 << w) - 64'd1;
        if (v[w-1]) return -longint'((~v) & mask);
        return longint'(v & mask);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Run one multiplication; returns product pattern and latency in edges.
    task automatic run_mul(input logic [N-1:0] a, input logic [N-1:0] x,
                           output logic [PW-1:0] p, output int lat);
        @(negedge clk);
        mcand = a; mplier = x; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        p = product;
        @(negedge clk);
        check(!done, "R5 pulse", longint'(done), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        logic [PW-1:0] p;
        int lat;
        longint exp, act;
        string tag;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!done && product == '0, "R1 reset", longint'(product), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!done && product == '0, "R1 idle", longint'(product), 0);

        // Exhaustive sweep: R2, R3, R4, R5.
        for (int ai = 0; ai < (1 << N); ai++) begin
            for (int xi = 0; xi < (1 << N); xi++) begin
                run_mul(N'(ai), N'(xi), p, lat);
                exp = oc_val(64'(ai), N) * oc_val(64'(xi), N);
                act = oc_val(64'(p), PW);
                if (ai == 0 || xi == 0 || ai == (1 << N) - 1 || xi == (1 << N) - 1)
                    tag = "R4";
                else if (xi >= (1 << (N - 1)))
                    tag = "R3";
                else
                    tag = "R2";
                check(act == exp, tag, act, exp);
                check(lat == N + 1, "R5 latency", lat, N + 1);
            end
        end

        // R9: -5 x 3 gives the exact pattern of -15.
        run_mul(~N'(5), N'(3), p, lat);
        check(p == ~PW'(15), "R9 pattern", longint'(p), longint'(~PW'(15)));

        // R8: end-around cases.
        run_mul(~N'(1), ~N'(1), p, lat);
        check(oc_val(64'(p), PW) == 1, "R8 -1*-1", oc_val(64'(p), PW), 1);
        run_mul(~N'((1 << (N - 1)) - 1), ~N'((1 << (N - 1)) - 1), p, lat);
        exp = longint'(((1 << (N - 1)) - 1) * ((1 << (N - 1)) - 1));
        check(oc_val(64'(p), PW) == exp, "R8 max", oc_val(64'(p), PW), exp);

        // R6: start mid-run with other operands is ignored.
        @(negedge clk);
        mcand = N'(5); mplier = N'(3); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        mcand = ~N'(7); mplier = ~N'(9); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        act = oc_val(64'(product), PW);
        check(act == 15, "R6 ignored", act, 15);
        @(negedge clk);
        check(!done, "R6 no second done", longint'(done), 0);

        // R7: product holds while idle.
        repeat (5) @(negedge clk);
        act = oc_val(64'(product), PW);
        check(act == 15 && !done, "R7 hold", act, 15);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule